// File: doc/BRIEF.md
# Programmable Parallel Port Register Core

This core gives a processor 24 general-purpose I/O lines, organised as three 8-bit ports called A, B and C, with port C further split into an upper and a lower nibble. The lines fall into two direction groups: port A with the upper half of C, and port B with the lower half of C. The processor reaches the core over an 8-bit data bus qualified by a select, a read strobe, a write strobe and a 2-bit register address. All writes take effect at the rising clock edge on which select and write are both high. Reads are combinational.

The control address accepts two kinds of byte, and its top bit chooses between them. With the top bit set, the byte defines the direction of each port or nibble for the basic I/O mode. With the top bit clear, the byte sets or clears one chosen bit of the port C output latch and leaves everything else alone. Output values are held in latches that drive the pad outputs. Per-line output enables drive tri-state pads. When a port is an input, reading it returns the live pin value. The handshake and bidirectional modes are not handled here. Control bytes that request them are dropped.

Top module: `pario_core`

## Requirements
- R1: After synchronous reset every port and nibble is an input (all output enables 0), and all three output latches hold 0x00.
- R2: Register address 2'b00 selects port A, 2'b01 selects port B, 2'b10 selects port C and 2'b11 selects the control register. A data write to 00, 01 or 10 loads the whole byte into that port's output latch, whatever the port's direction. The latch value always appears on that port's output pins.
- R3: A control write with bit 7 = 1 and bits 6, 5 and 2 all 0 sets the directions. Bit 4 controls port A, bit 1 port B, bit 3 the C upper nibble (PC7..PC4) and bit 0 the C lower nibble (PC3..PC0). A value of 1 means input. An output port drives its output enables to all ones, and an input port drives them to all zeros.
- R4: Every accepted direction write (R3) clears all three output latches to 0x00 at the same edge.
- R5: A control write with bit 7 = 0 sets port C latch bit number wdata[3:1] to wdata[0] (for example, 0x09 sets PC4). All other latch bits and all directions stay unchanged.
- R6: A control write with bit 7 = 1 and any of bits 6, 5 or 2 set is ignored: directions and latches keep their values.
- R7: A read of a port configured as output returns its latch. A read of a port configured as input returns its pins. The two halves of port C follow their own direction bits independently.
- R8: A read of the control address returns 0x00. The read data is 0x00 whenever select and read are not both high.
- R9: A write strobe without select changes no latch and no direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high, sampled at the clock edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, upper and lower nibble separate |

## Verification
The bench uses mixed direction patterns in which the two port C nibbles point in opposite ways. A read mux that treated port C as one unit would return the pins or the latch for the whole byte. The bench sends a chain of single-bit commands, including one that rewrites a bit to the value it already holds. A command that disturbed neighbouring bits, or that reached ports A and B, would show up in the readback. It also writes reserved mode bytes, which would wrongly clear the latches or change directions if accepted. Finally, it writes strobes without select and reads the control address, where a bad decode would leak data.

// File: rtl/pario_pkg.sv
// Shared constants and types for the parallel port register core.
// Assumes the bus and every port are one byte wide.
package pario_pkg;
    localparam int PORT_W    = 8;
    localparam int NIB_W     = PORT_W / 2;
    localparam int BIT_IDX_W = $clog2(PORT_W);
    localparam int NUM_PORTS = 3;

    localparam int PORT_A = 0;
    localparam int PORT_B = 1;
    localparam int PORT_C = 2;

    // Register address map; the decode depends on these values.
    typedef enum logic [1:0] {
        REG_PA  = 2'b00,
        REG_PB  = 2'b01,
        REG_PC  = 2'b10,
        REG_CTL = 2'b11
    } reg_sel_e;

    // Direction flags, 1 = input.
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } dir_t;

    localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pario_ctrl.sv
// Control word decoder and direction register.
// Splits a control write into a basic-mode direction load or a port C bit
// command, and drops mode bytes that ask for unsupported modes.
// Assumes ctl_wr is a one-cycle qualified write to the control address.
module pario_ctrl
    import pario_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic [PORT_W-1:0]    wdata,
    output dir_t                 dir,
    output logic                 mode_load,
    output logic                 bsr_load,
    output logic [BIT_IDX_W-1:0] bsr_idx,
    output logic                 bsr_val
);
    logic is_mode_byte;
    logic mode_supported;
    logic chk_armed;

    // Classify the control byte.
    always_comb begin
        is_mode_byte   = wdata[7];
        mode_supported = ~wdata[6] & ~wdata[5] & ~wdata[2];
        mode_load      = ctl_wr & is_mode_byte & mode_supported;
        bsr_load       = ctl_wr & ~is_mode_byte;
        bsr_idx        = wdata[BIT_IDX_W:1];
        bsr_val        = wdata[0];
    end

    // Direction register, loaded only by an accepted mode byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= DIR_RESET;
        end else if (mode_load) begin
            dir.a_in  <= wdata[4];
            dir.b_in  <= wdata[1];
            dir.cu_in <= wdata[3];
            dir.cl_in <= wdata[0];
        end
    end

    // Arms the checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    // R3: directions change only after an accepted mode write.
    a_r3_dir_only_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && !$past(mode_load)) |-> $stable(dir))
        else $error("direction changed without a mode write");

    // R6: a reserved mode byte leaves directions alone.
    a_r6_reserved_mode_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(ctl_wr && wdata[7] && (wdata[6] || wdata[5] || wdata[2])))
        |-> $stable(dir))
        else $error("reserved mode byte altered directions");
endmodule

// File: rtl/pario_latch.sv
// One output latch of a port.
// Priority: clear, then byte write, then single-bit command. The bit path
// exists only when HAS_BIT is set; otherwise bit_* inputs are unused.
module pario_latch #(
    parameter int W       = 8,
    parameter bit HAS_BIT = 1'b0,
    localparam int IDX_W  = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [W-1:0]     wdata,
    input  logic             bit_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);
    logic [W-1:0] bit_next;
    logic         bit_go;
    logic         chk_armed;

    // Single-bit update path, present only when requested.
    generate
        if (HAS_BIT) begin : g_bit
            always_comb begin
                bit_next          = q;
                bit_next[bit_idx] = bit_val;
                bit_go            = bit_en;
            end
        end else begin : g_nobit
            always_comb begin
                bit_next = q;
                bit_go   = 1'b0;
            end
        end
    endgenerate

    // Latch register with its update priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (wr_en)  q <= wdata;
        else if (bit_go) q <= bit_next;
    end

    // Arms the checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    // R4: a clear request leaves the latch at zero.
    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(clr)) |-> (q == '0))
        else $error("latch not cleared");

    // R5: a bit command flips at most one latch bit.
    a_r5_one_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(bit_en && !clr && !wr_en)) |-> ($countones(q ^ $past(q)) <= 1))
        else $error("bit command touched more than one bit");

    // R9: with no request at all the latch holds.
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(!clr && !wr_en && !bit_en)) |-> $stable(q))
        else $error("latch changed without a request");
endmodule

// File: rtl/pario_rdmux.sv
// Read-data selector: per port (per nibble for port C) chooses the live pins
// for inputs or the latch for outputs. Purely combinational.
module pario_rdmux
    import pario_pkg::*;
(
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  dir_t              dir,
    input  logic [PORT_W-1:0] a_lat,
    input  logic [PORT_W-1:0] b_lat,
    input  logic [PORT_W-1:0] c_lat,
    input  logic [PORT_W-1:0] a_pin,
    input  logic [PORT_W-1:0] b_pin,
    input  logic [PORT_W-1:0] c_pin,
    output logic [PORT_W-1:0] rdata
);
    logic [PORT_W-1:0] a_view;
    logic [PORT_W-1:0] b_view;
    logic [PORT_W-1:0] c_view;

    // Build the view of each port as the processor sees it.
    always_comb begin
        a_view = dir.a_in ? a_pin : a_lat;
        b_view = dir.b_in ? b_pin : b_lat;
        c_view[PORT_W-1:NIB_W] = dir.cu_in ? c_pin[PORT_W-1:NIB_W] : c_lat[PORT_W-1:NIB_W];
        c_view[NIB_W-1:0]      = dir.cl_in ? c_pin[NIB_W-1:0]      : c_lat[NIB_W-1:0];
    end

    // Select by address; idle and control reads return zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_sel_e'(addr))
                REG_PA:  rdata = a_view;
                REG_PB:  rdata = b_view;
                REG_PC:  rdata = c_view;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pario_core.sv
// Top of the parallel port register core.
// Decodes bus writes into latch loads and control commands, drives output
// latches and tri-state enables, and returns read data. Assumes a write
// strobe lasts one clock per transfer.
module pario_core
    import pario_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic [7:0]  pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);
    logic                 wr_hit;
    logic                 rd_hit;
    logic                 ctl_wr;
    logic [NUM_PORTS-1:0] port_wr;
    dir_t                 dir;
    logic                 mode_load;
    logic                 bsr_load;
    logic [BIT_IDX_W-1:0] bsr_idx;
    logic                 bsr_val;
    logic [PORT_W-1:0]    lat_q [NUM_PORTS];

    // Qualify bus strobes and decode the write target.
    always_comb begin
        wr_hit  = bus_sel & bus_wr;
        rd_hit  = bus_sel & bus_rd;
        ctl_wr  = wr_hit & (bus_addr == REG_CTL);
        port_wr = '0;
        port_wr[PORT_A] = wr_hit & (bus_addr == REG_PA);
        port_wr[PORT_B] = wr_hit & (bus_addr == REG_PB);
        port_wr[PORT_C] = wr_hit & (bus_addr == REG_PC);
    end

    pario_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .wdata     (bus_wdata),
        .dir       (dir),
        .mode_load (mode_load),
        .bsr_load  (bsr_load),
        .bsr_idx   (bsr_idx),
        .bsr_val   (bsr_val)
    );

    // One latch per port; only port C accepts single-bit commands.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            pario_latch #(
                .W       (PORT_W),
                .HAS_BIT (p == PORT_C)
            ) u_latch (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (mode_load),
                .wr_en   (port_wr[p]),
                .wdata   (bus_wdata),
                .bit_en  (bsr_load && (p == PORT_C)),
                .bit_idx (bsr_idx),
                .bit_val (bsr_val),
                .q       (lat_q[p])
            );
        end
    endgenerate

    // Drive pad data and enables from latches and directions.
    always_comb begin
        pa_out = lat_q[PORT_A];
        pb_out = lat_q[PORT_B];
        pc_out = lat_q[PORT_C];
        pa_oe  = {PORT_W{~dir.a_in}};
        pb_oe  = {PORT_W{~dir.b_in}};
        pc_oe  = {{NIB_W{~dir.cu_in}}, {NIB_W{~dir.cl_in}}};
    end

    pario_rdmux u_rdmux (
        .rd_en (rd_hit),
        .addr  (bus_addr),
        .dir   (dir),
        .a_lat (lat_q[PORT_A]),
        .b_lat (lat_q[PORT_B]),
        .c_lat (lat_q[PORT_C]),
        .a_pin (pa_in),
        .b_pin (pb_in),
        .c_pin (pc_in),
        .rdata (bus_rdata)
    );

    // R8: the control address never reads back data.
    a_r8_ctl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == 2'b11) |-> (bus_rdata == 8'h00))
        else $error("control read returned data");

    // R7: reading port A while it drives returns what it drives.
    a_r7_out_port_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == 2'b00 && pa_oe == 8'hFF) |-> (bus_rdata == pa_out))
        else $error("output port readback mismatch");

    // R5: a single-bit command leaves ports A and B and the enables unchanged.
    a_r5_bsr_spares_others: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && bus_sel && bus_wr && bus_addr == 2'b11 && !bus_wdata[7])
        |-> ($stable(pa_out) && $stable(pb_out) && $stable(pc_oe) && $stable(pa_oe)))
        else $error("bit command disturbed other state");
endmodule

// File: tb/pario_core_bench.sv
// Scoreboard bench: driver tasks push expected read data, a monitor pops and
// compares it at the clock edge where the read is presented.
module pario_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    pario_core u_pario_core (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_read(input logic [1:0] a, input logic [7:0] exp, input string req);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        it.exp = exp; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    // Monitor: compare each presented read against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_sel && bus_rd) begin
                if (sb_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL scoreboard actual=%h expected=none", bus_rdata);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check8(bus_rdata, it.exp, it.req);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check8(pa_oe, 8'h00, "R1 pa_oe");
        check8(pb_oe, 8'h00, "R1 pb_oe");
        check8(pc_oe, 8'h00, "R1 pc_oe");
        check8(pc_out, 8'h00, "R1 pc_out");
        pa_in = 8'h5A;
        expect_read(2'b00, 8'h5A, "R1 input read of A");

        // R2: latch loads while input; pins still read
        bus_write(2'b00, 8'h3C, 1'b1);
        check8(pa_out, 8'h3C, "R2 latch loads while input");
        expect_read(2'b00, 8'h5A, "R7 input port reads pins");

        // R3/R4: all outputs
        bus_write(2'b11, 8'h80, 1'b1);
        check8(pa_oe, 8'hFF, "R3 pa_oe all out");
        check8(pb_oe, 8'hFF, "R3 pb_oe all out");
        check8(pc_oe, 8'hFF, "R3 pc_oe all out");
        check8(pa_out, 8'h00, "R4 mode clears A");

        // R2/R7: data writes and readback
        bus_write(2'b00, 8'hA5, 1'b1);
        bus_write(2'b01, 8'h5A, 1'b1);
        bus_write(2'b10, 8'h00, 1'b1);
        expect_read(2'b00, 8'hA5, "R7 A readback");
        expect_read(2'b01, 8'h5A, "R2 B readback");

        // R5: bit commands on C
        bus_write(2'b11, 8'h09, 1'b1);
        check8(pc_out, 8'h10, "R5 0x09 sets PC4");
        bus_write(2'b11, 8'h0F, 1'b1);
        check8(pc_out, 8'h90, "R5 set PC7");
        bus_write(2'b11, 8'h0F, 1'b1);
        check8(pc_out, 8'h90, "R5 repeat set no change");
        bus_write(2'b11, 8'h08, 1'b1);
        check8(pc_out, 8'h80, "R5 clear PC4");
        check8(pa_out, 8'hA5, "R5 A untouched");
        check8(pb_out, 8'h5A, "R5 B untouched");
        check8(pc_oe, 8'hFF, "R5 directions untouched");

        // R6: reserved mode bytes dropped
        bus_write(2'b11, 8'hC0, 1'b1);
        bus_write(2'b11, 8'h9F, 1'b1);
        check8(pa_oe, 8'hFF, "R6 directions kept");
        check8(pa_out, 8'hA5, "R6 A latch kept");
        expect_read(2'b10, 8'h80, "R6 C latch kept");

        // R3/R7: mixed directions, A in, B out, C upper out, C lower in
        bus_write(2'b11, 8'h91, 1'b1);
        check8(pa_oe, 8'h00, "R3 A input");
        check8(pb_oe, 8'hFF, "R3 B output");
        check8(pc_oe, 8'hF0, "R3 C split");
        check8(pb_out, 8'h00, "R4 mixed mode clears B");
        bus_write(2'b10, 8'hFF, 1'b1);
        pc_in = 8'h3C; pa_in = 8'h77;
        expect_read(2'b10, 8'hFC, "R7 C nibbles independent");
        expect_read(2'b00, 8'h77, "R7 A pins");

        // Opposite split: C upper in, B in, A out
        bus_write(2'b11, 8'h8A, 1'b1);
        check8(pc_oe, 8'h0F, "R3 C opposite split");
        check8(pb_oe, 8'h00, "R3 B input");
        bus_write(2'b10, 8'h96, 1'b1);
        expect_read(2'b10, 8'h36, "R7 C upper pins lower latch");

        // R8: control read and idle read data
        expect_read(2'b11, 8'h00, "R8 control read");
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b1; bus_addr = 2'b00;
        #1 check8(bus_rdata, 8'h00, "R8 unselected read");
        bus_rd = 1'b0;

        // R9: write without select
        bus_write(2'b00, 8'h55, 1'b0);
        check8(pa_out, 8'h00, "R9 no select no latch");
        bus_write(2'b11, 8'h80, 1'b0);
        check8(pc_oe, 8'h0F, "R9 no select no mode");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule